// File: doc/BRIEF.md
# Multi-Layer Alpha Compositor

This block overlays up to four rectangular pixel layers onto a solid background colour and emits the result as one raster-order pixel stream. Each layer has its own window, given as an offset and a size inside the output frame. Each layer feeds one blend stage, and the stages are chained. The first stage takes the background as its destination. Each later stage takes the result of the stage before it. A layer can be switched off, and a layer can carry premultiplied colour instead of straight colour.

Each layer arrives on its own valid/ready stream that carries the visible part of its window in raster order. The block pulls a pixel from a layer only when the current output pixel lies inside that layer's window and the output is accepted downstream. A flat set of configuration inputs sets the frame size, the background colour and, per layer, the enable, premultiplied flag, offset and size. These inputs are sampled in a single idle cycle before each frame, so software can rewrite them at any time without tearing a frame.

Top module: `layer_compositor`

## Requirements
- R1: Every pixel is 32 bits, with alpha in bits 31:24 and three 8-bit colour channels in bits 23:16, 15:8 and 7:0. The background pixel is 0xFF in the alpha byte and the 24-bit background colour below it. The background colour resets to 0.
- R2: Layer i drives stage i. Stage 0 blends over the background, and stage i+1 blends over the result of stage i, so a higher layer index lands on top.
- R3: For a straight-alpha layer with source alpha a, each colour channel becomes rnd(d*(255-a)/255) + rnd(s*a/255), and alpha becomes rnd(D*(255-a)/255) + a. Here rnd() rounds to the nearest integer and every sum saturates at 255.
- R4: For a layer whose premultiplied flag is 1, each colour channel becomes rnd(d*(255-a)/255) + s, saturating at 255. Alpha follows the R3 rule.
- R5: A disabled layer passes its destination through unchanged, and its in_ready stays 0 whatever its in_valid does.
- R6: A stage passes its destination through for any pixel outside its layer's window. Window parts that fall beyond the frame are clipped, and the layer stream carries only the clipped window's pixels.
- R7: A layer's x offset is clamped to frame width - 1 and its y offset to frame height - 1. Its width and height are clamped to the range 1 to 8190.
- R8: The output frame width and height are clamped to the range 1 to 8190. A value of 0 becomes 1.
- R9: out_valid is low while any enabled layer covering the current pixel has in_valid low. A layer's in_ready is high exactly when it covers the pixel and out_valid and out_ready are both high. A stalled output holds its data.
- R10: Configuration is sampled in one idle cycle (out_valid low) after reset and after the last pixel of each frame. Changes made during a frame have no effect on that frame.
- R11: out_sof marks pixel (0,0) of each frame, and out_eol marks the last pixel of every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bg_color | input | 24 | Background colour |
| cfg_frame_w | input | CFG_W | Output frame width in pixels |
| cfg_frame_h | input | CFG_W | Output frame height in lines |
| cfg_layer_en | input | NL | Per-layer enable |
| cfg_layer_premul | input | NL | Per-layer premultiplied-colour flag |
| cfg_layer_x | input | NL*CFG_W | Per-layer x offset, layer i at bits i*CFG_W |
| cfg_layer_y | input | NL*CFG_W | Per-layer y offset |
| cfg_layer_w | input | NL*CFG_W | Per-layer window width |
| cfg_layer_h | input | NL*CFG_W | Per-layer window height |
| in_valid | input | NL | Per-layer pixel valid |
| in_ready | output | NL | Per-layer pixel accepted |
| in_data | input | NL*32 | Per-layer pixel, layer i at bits i*32 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel accepted downstream |
| out_data | output | 32 | Composited pixel |
| out_sof | output | 1 | First pixel of the frame |
| out_eol | output | 1 | Last pixel of a line |

## Verification
The bench builds the block with its defaults: four layers, a 16-bit configuration field width and a maximum dimension of 8190. The 16-bit fields let the bench program sizes and offsets above the limits, so the clamps of R7 and R8 come into play, including a frame width of 9000. The full maximum dimension lets one frame run a single 8190-pixel line with a window clipped at its right edge. With four layers, all stages can stack over one pixel, with straight and premultiplied layers mixed and alphas of 0 and 255 forced often.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  localparam int PIX_W = 32;
  localparam int CH_W  = 8;

  function automatic logic [15:0] mul8(input logic [7:0] a, input logic [7:0] b);
    return {8'd0, a} * {8'd0, b};
  endfunction

  // Rounded division of a product of two bytes by 255.
  function automatic logic [7:0] div255(input logic [15:0] p);
    logic [16:0] t;
    t = {1'b0, p} + 17'd128;
    t = t + (t >> 8);
    return t[15:8];
  endfunction

  function automatic logic [7:0] sat_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8] ? 8'hFF : s[7:0];
  endfunction

  function automatic logic [PIX_W-1:0] blend_px(input logic [PIX_W-1:0] dst,
                                                input logic [PIX_W-1:0] src,
                                                input logic             premul);
    logic [7:0] sa, inv, keep, add;
    logic [PIX_W-1:0] res;
    sa  = src[31:24];
    inv = 8'd255 - sa;
    res[31:24] = sat_add(div255(mul8(dst[31:24], inv)), sa);
    for (int k = 0; k < 3; k++) begin
      keep = div255(mul8(dst[k*CH_W +: CH_W], inv));
      add  = premul ? src[k*CH_W +: CH_W] : div255(mul8(src[k*CH_W +: CH_W], sa));
      res[k*CH_W +: CH_W] = sat_add(keep, add);
    end
    return res;
  endfunction

endpackage

// File: rtl/cmp_cfg_shadow.sv
module cmp_cfg_shadow #(
  parameter int NL      = 4,
  parameter int CFG_W   = 16,
  parameter int MAX_DIM = 8190,
  parameter int DW      = $clog2(MAX_DIM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [23:0]       cfg_bg_color,
  input  logic [CFG_W-1:0]  cfg_frame_w,
  input  logic [CFG_W-1:0]  cfg_frame_h,
  input  logic [NL-1:0]     cfg_layer_en,
  input  logic [NL-1:0]     cfg_layer_premul,
  input  logic [NL*CFG_W-1:0] cfg_layer_x,
  input  logic [NL*CFG_W-1:0] cfg_layer_y,
  input  logic [NL*CFG_W-1:0] cfg_layer_w,
  input  logic [NL*CFG_W-1:0] cfg_layer_h,
  output logic [23:0]       sh_bg,
  output logic [DW-1:0]     sh_w,
  output logic [DW-1:0]     sh_h,
  output logic [NL-1:0]     sh_en,
  output logic [NL-1:0]     sh_premul,
  output logic [DW-1:0]     sh_lx [NL],
  output logic [DW-1:0]     sh_ly [NL],
  output logic [DW-1:0]     sh_lw [NL],
  output logic [DW-1:0]     sh_lh [NL]
);

  function automatic logic [DW-1:0] clamp_dim(input logic [CFG_W-1:0] v);
    if (v == '0) return DW'(1);
    if (v > CFG_W'(MAX_DIM)) return DW'(MAX_DIM);
    return v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] clamp_off(input logic [CFG_W-1:0] v,
                                              input logic [DW-1:0] lim);
    if (v > CFG_W'(lim) - CFG_W'(1)) return lim - DW'(1);
    return v[DW-1:0];
  endfunction

  logic [DW-1:0] w_c, h_c;
  assign w_c = clamp_dim(cfg_frame_w);
  assign h_c = clamp_dim(cfg_frame_h);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_bg     <= '0;
      sh_w      <= DW'(1);
      sh_h      <= DW'(1);
      sh_en     <= '0;
      sh_premul <= '0;
    end else if (load) begin
      sh_bg     <= cfg_bg_color;
      sh_w      <= w_c;
      sh_h      <= h_c;
      sh_en     <= cfg_layer_en;
      sh_premul <= cfg_layer_premul;
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_layer
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_lx[g] <= '0;
        sh_ly[g] <= '0;
        sh_lw[g] <= DW'(1);
        sh_lh[g] <= DW'(1);
      end else if (load) begin
        sh_lx[g] <= clamp_off(cfg_layer_x[g*CFG_W +: CFG_W], w_c);
        sh_ly[g] <= clamp_off(cfg_layer_y[g*CFG_W +: CFG_W], h_c);
        sh_lw[g] <= clamp_dim(cfg_layer_w[g*CFG_W +: CFG_W]);
        sh_lh[g] <= clamp_dim(cfg_layer_h[g*CFG_W +: CFG_W]);
      end
    end
  end

endmodule

// File: rtl/cmp_raster.sv
module cmp_raster #(
  parameter int DW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [DW-1:0] frame_w,
  input  logic [DW-1:0] frame_h,
  output logic [DW-1:0] pos_x,
  output logic [DW-1:0] pos_y,
  output logic          armed,
  output logic          sof,
  output logic          eol
);

  logic last_line;

  assign eol       = (pos_x == frame_w - DW'(1));
  assign sof       = (pos_x == '0) && (pos_y == '0);
  assign last_line = (pos_y == frame_h - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_x <= '0;
      pos_y <= '0;
      armed <= 1'b1;
    end else if (armed) begin
      armed <= 1'b0;
    end else if (fire) begin
      if (eol) begin
        pos_x <= '0;
        if (last_line) begin
          pos_y <= '0;
          armed <= 1'b1;
        end else begin
          pos_y <= pos_y + DW'(1);
        end
      end else begin
        pos_x <= pos_x + DW'(1);
      end
    end
  end

endmodule

// File: rtl/cmp_blend_stage.sv
module cmp_blend_stage #(
  parameter int DW = 13
) (
  input  logic                       en,
  input  logic                       premul,
  input  logic [DW-1:0]              lx,
  input  logic [DW-1:0]              ly,
  input  logic [DW-1:0]              lw,
  input  logic [DW-1:0]              lh,
  input  logic [DW-1:0]              pos_x,
  input  logic [DW-1:0]              pos_y,
  input  logic [cmp_pkg::PIX_W-1:0]  dst,
  input  logic [cmp_pkg::PIX_W-1:0]  src,
  output logic                       covers,
  output logic [cmp_pkg::PIX_W-1:0]  res
);

  logic in_x, in_y;

  assign in_x = (pos_x >= lx) && ({1'b0, pos_x} < ({1'b0, lx} + {1'b0, lw}));
  assign in_y = (pos_y >= ly) && ({1'b0, pos_y} < ({1'b0, ly} + {1'b0, lh}));
  assign covers = en && in_x && in_y;
  assign res = covers ? cmp_pkg::blend_px(dst, src, premul) : dst;

endmodule

// File: rtl/layer_compositor.sv
module layer_compositor #(
  parameter int NL      = 4,
  parameter int CFG_W   = 16,
  parameter int MAX_DIM = 8190
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [23:0]          cfg_bg_color,
  input  logic [CFG_W-1:0]     cfg_frame_w,
  input  logic [CFG_W-1:0]     cfg_frame_h,
  input  logic [NL-1:0]        cfg_layer_en,
  input  logic [NL-1:0]        cfg_layer_premul,
  input  logic [NL*CFG_W-1:0]  cfg_layer_x,
  input  logic [NL*CFG_W-1:0]  cfg_layer_y,
  input  logic [NL*CFG_W-1:0]  cfg_layer_w,
  input  logic [NL*CFG_W-1:0]  cfg_layer_h,
  input  logic [NL-1:0]        in_valid,
  output logic [NL-1:0]        in_ready,
  input  logic [NL*32-1:0]     in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [31:0]          out_data,
  output logic                 out_sof,
  output logic                 out_eol
);

  localparam int DW = $clog2(MAX_DIM + 1);
  localparam int PW = cmp_pkg::PIX_W;

  logic [23:0]   sh_bg;
  logic [DW-1:0] sh_w, sh_h;
  logic [NL-1:0] sh_en, sh_premul;
  logic [DW-1:0] sh_lx [NL];
  logic [DW-1:0] sh_ly [NL];
  logic [DW-1:0] sh_lw [NL];
  logic [DW-1:0] sh_lh [NL];

  logic [DW-1:0] pos_x, pos_y;
  logic          frame_armed;
  logic          pix_fire;
  logic [NL-1:0] layer_need;
  logic [PW-1:0] chain [NL+1];

  cmp_cfg_shadow #(.NL(NL), .CFG_W(CFG_W), .MAX_DIM(MAX_DIM), .DW(DW)) u_shadow (
    .clk, .rst_n,
    .load             (frame_armed),
    .cfg_bg_color, .cfg_frame_w, .cfg_frame_h,
    .cfg_layer_en, .cfg_layer_premul,
    .cfg_layer_x, .cfg_layer_y, .cfg_layer_w, .cfg_layer_h,
    .sh_bg, .sh_w, .sh_h, .sh_en, .sh_premul,
    .sh_lx, .sh_ly, .sh_lw, .sh_lh
  );

  cmp_raster #(.DW(DW)) u_raster (
    .clk, .rst_n,
    .fire    (pix_fire),
    .frame_w (sh_w),
    .frame_h (sh_h),
    .pos_x, .pos_y,
    .armed   (frame_armed),
    .sof     (out_sof),
    .eol     (out_eol)
  );

  assign chain[0] = {8'hFF, sh_bg};

  for (genvar g = 0; g < NL; g++) begin : g_stage
    cmp_blend_stage #(.DW(DW)) u_stage (
      .en     (sh_en[g]),
      .premul (sh_premul[g]),
      .lx     (sh_lx[g]),
      .ly     (sh_ly[g]),
      .lw     (sh_lw[g]),
      .lh     (sh_lh[g]),
      .pos_x, .pos_y,
      .dst    (chain[g]),
      .src    (in_data[g*PW +: PW]),
      .covers (layer_need[g]),
      .res    (chain[g+1])
    );
  end

  assign out_valid = !frame_armed && ((layer_need & ~in_valid) == '0);
  assign pix_fire  = out_valid && out_ready;
  assign in_ready  = layer_need & {NL{pix_fire}};
  assign out_data  = chain[NL];

endmodule

// File: rtl/layer_compositor_chk.sv
module layer_compositor_chk #(
  parameter int NL = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] in_valid,
  input logic [NL-1:0] in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [31:0]   out_data,
  input logic          out_sof,
  input logic          armed
);

  p_ready_on_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready != '0) |-> (out_valid && out_ready));

  p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_idle_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !out_valid);

  p_sof_after_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> out_sof);

endmodule

bind layer_compositor layer_compositor_chk #(.NL(NL)) u_chk (
  .clk, .rst_n, .in_valid, .in_ready, .out_valid, .out_ready, .out_data,
  .out_sof, .armed(frame_armed)
);

// File: tb/sim_layer_compositor.sv
module sim_layer_compositor;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int CW = 16;
  localparam int MAXD = 8190;
  localparam int NFRAMES = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [23:0]      s_bg;
  logic [CW-1:0]    s_w, s_h;
  logic [NL-1:0]    s_en, s_pm;
  logic [CW-1:0]    s_x [NL];
  logic [CW-1:0]    s_y [NL];
  logic [CW-1:0]    s_lw [NL];
  logic [CW-1:0]    s_lh [NL];
  logic [NL*CW-1:0] bx, by, bw, bh;
  logic [NL-1:0]    in_valid, in_ready;
  logic [NL*32-1:0] in_data;
  logic             out_valid, out_ready, out_sof, out_eol;
  logic [31:0]      out_data;

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      bx[i*CW +: CW] = s_x[i];
      by[i*CW +: CW] = s_y[i];
      bw[i*CW +: CW] = s_lw[i];
      bh[i*CW +: CW] = s_lh[i];
    end
  end

  layer_compositor #(.NL(NL), .CFG_W(CW), .MAX_DIM(MAXD)) u0 (
    .clk, .rst_n,
    .cfg_bg_color(s_bg), .cfg_frame_w(s_w), .cfg_frame_h(s_h),
    .cfg_layer_en(s_en), .cfg_layer_premul(s_pm),
    .cfg_layer_x(bx), .cfg_layer_y(by), .cfg_layer_w(bw), .cfg_layer_h(bh),
    .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .out_sof, .out_eol
  );

  int checks = 0;
  int errors = 0;

  // Reference model state
  int m_armed, m_x, m_y, m_w, m_h, m_bg, frame_idx;
  int m_en [NL];
  int m_pm [NL];
  int m_lx [NL];
  int m_ly [NL];
  int m_lw [NL];
  int m_lh [NL];
  logic [31:0] lq [NL][$];
  logic        held [NL];

  function automatic int clampd(int v);
    if (v < 1) return 1;
    if (v > MAXD) return MAXD;
    return v;
  endfunction

  function automatic int rdiv(int p);
    return (2 * p + 255) / 510;
  endfunction

  function automatic int minsat(int v);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic logic [31:0] ref_blend(logic [31:0] d, logic [31:0] s, int pm);
    int sa, o [4];
    sa = int'(s[31:24]);
    o[3] = minsat(rdiv(int'(d[31:24]) * (255 - sa)) + sa);
    for (int k = 0; k < 3; k++) begin
      int dc, sc;
      dc = int'(d[8*k +: 8]);
      sc = int'(s[8*k +: 8]);
      o[k] = minsat(rdiv(dc * (255 - sa)) + (pm != 0 ? sc : rdiv(sc * sa)));
    end
    return {o[3][7:0], o[2][7:0], o[1][7:0], o[0][7:0]};
  endfunction

  function automatic logic [31:0] rand_px();
    int r;
    logic [7:0] a;
    r = $urandom % 3;
    a = (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : 8'($urandom);
    return {a, 24'($urandom)};
  endfunction

  function automatic bit covers(int i, int x, int y);
    return m_en[i] != 0 && x >= m_lx[i] && x < m_lx[i] + m_lw[i] &&
           y >= m_ly[i] && y < m_ly[i] + m_lh[i];
  endfunction

  task automatic lay(int i, int pm, int x, int y, int w, int h);
    s_en[i] = 1'b1; s_pm[i] = pm[0];
    s_x[i] = CW'(x); s_y[i] = CW'(y); s_lw[i] = CW'(w); s_lh[i] = CW'(h);
  endtask

  task automatic set_scn(int f);
    s_en = '0; s_pm = '0;
    for (int i = 0; i < NL; i++) begin
      s_x[i] = '0; s_y[i] = '0; s_lw[i] = 16'd1; s_lh[i] = 16'd1;
    end
    case (f)
      0: begin s_bg = 24'h123456; s_w = 6; s_h = 4; end        // R1 background only
      1: begin s_bg = 24'h00FF80; s_w = 8; s_h = 5;
               lay(0, 0, 1, 1, 4, 3); lay(2, 1, 3, 0, 4, 4); lay(3, 0, 6, 3, 5, 5); end // R6 clip
      2: begin s_bg = 24'hA0A0A0; s_w = 7; s_h = 6;
               lay(0, 0, 0, 0, 7, 6); lay(1, 1, 1, 1, 5, 4);
               lay(2, 0, 2, 2, 4, 4); lay(3, 1, 3, 0, 3, 6); end // R2 stack
      3: begin s_bg = 24'h0000FF; s_w = 8; s_h = 5;
               lay(1, 0, 100, 50, 3, 2); lay(2, 1, 9, 2, 0, 0); end // R7 clamp
      4: begin s_bg = 24'hFFFFFF; s_w = 0; s_h = 0; lay(0, 1, 0, 0, 1, 1); end // R8 zero
      5: begin s_bg = 24'h102030; s_w = 9000; s_h = 1;
               lay(0, 0, 0, 0, 20000, 1); lay(3, 1, 8188, 0, 3, 1); end // R8 max
      default: begin s_bg = 24'h5A5A5A; s_w = 5; s_h = 5;
               lay(0, 1, 0, 0, 5, 5); lay(1, 0, 0, 0, 5, 5);
               lay(2, 1, 2, 2, 9, 9); lay(3, 0, 1, 1, 2, 2); end
    endcase
  endtask

  task automatic latch_model();
    int vw, vh;
    m_w = clampd(int'(s_w)); m_h = clampd(int'(s_h)); m_bg = int'(s_bg);
    for (int i = 0; i < NL; i++) begin
      m_en[i] = int'(s_en[i]); m_pm[i] = int'(s_pm[i]);
      m_lx[i] = (int'(s_x[i]) > m_w - 1) ? m_w - 1 : int'(s_x[i]);
      m_ly[i] = (int'(s_y[i]) > m_h - 1) ? m_h - 1 : int'(s_y[i]);
      m_lw[i] = clampd(int'(s_lw[i])); m_lh[i] = clampd(int'(s_lh[i]));
      lq[i].delete();
      held[i] = 1'b0;
      if (m_en[i] != 0) begin
        vw = ((m_lx[i] + m_lw[i] > m_w) ? m_w : m_lx[i] + m_lw[i]) - m_lx[i];
        vh = ((m_ly[i] + m_lh[i] > m_h) ? m_h : m_ly[i] + m_lh[i]) - m_ly[i];
        for (int n = 0; n < vw * vh; n++) lq[i].push_back(rand_px());
      end
    end
  endtask

  task automatic fail(string req, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s at frame %0d (%0d,%0d): actual %h expected %h", req, frame_idx, m_x, m_y, act, exp);
  endtask

  initial begin
    int cyc;
    logic        e_valid;
    logic [NL-1:0] e_ready;
    logic [31:0] e_pix;
    logic [NL-1:0] cov;

    s_bg = '0; s_w = '0; s_h = '0; s_en = '0; s_pm = '0;
    for (int i = 0; i < NL; i++) begin
      s_x[i] = '0; s_y[i] = '0; s_lw[i] = '0; s_lh[i] = '0;
    end
    in_valid = '0; in_data = '0; out_ready = 1'b0;
    m_armed = 1; m_x = 0; m_y = 0; frame_idx = 0;
    for (int i = 0; i < NL; i++) begin
      m_en[i] = 0; held[i] = 1'b0;
    end

    repeat (3) @(negedge clk);
    // R10: reset state, nothing offered and nothing consumed
    checks++;
    if (out_valid !== 1'b0 || in_ready !== '0) fail("R10 reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;

    cyc = 0;
    while (frame_idx < NFRAMES) begin
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
        break;
      end
      // drive step
      if (m_armed != 0) set_scn(frame_idx);
      else begin  // R10: scrambled configuration mid-frame
        s_bg = 24'($urandom); s_w = 16'($urandom); s_h = 16'($urandom);
        s_en = 4'($urandom); s_pm = 4'($urandom);
        for (int i = 0; i < NL; i++) begin
          s_x[i] = 16'($urandom); s_y[i] = 16'($urandom);
          s_lw[i] = 16'($urandom); s_lh[i] = 16'($urandom);
        end
      end
      for (int i = 0; i < NL; i++) begin
        if (m_armed != 0) begin
          in_valid[i] = 1'b0;
        end else if (m_en[i] == 0) begin
          in_valid[i] = 1'b1;                     // R5: junk on a disabled layer
          in_data[i*32 +: 32] = 32'hFF00FF00;
        end else if (!held[i] && lq[i].size() > 0 && ($urandom % 4) != 0) begin
          held[i] = 1'b1;
        end
        if (m_armed == 0 && m_en[i] != 0) begin
          in_valid[i] = held[i];
          if (held[i]) in_data[i*32 +: 32] = lq[i][0];
        end
      end
      out_ready = (($urandom % 5) != 0);
      #1;
      // expected outputs
      e_pix = {8'hFF, m_bg[23:0]};
      cov = '0;
      for (int i = 0; i < NL; i++) begin
        if (m_armed == 0 && covers(i, m_x, m_y)) begin
          cov[i] = 1'b1;
          e_pix = ref_blend(e_pix, in_data[i*32 +: 32], m_pm[i]);
        end
      end
      e_valid = (m_armed == 0) && ((cov & ~in_valid) == '0);
      e_ready = (e_valid && out_ready) ? cov : '0;
      checks++;
      if (out_valid !== e_valid) fail("R9 R10 valid", {31'd0, out_valid}, {31'd0, e_valid});
      checks++;
      if (in_ready !== e_ready) fail("R5 R9 ready", {28'd0, in_ready}, {28'd0, e_ready});
      if (e_valid) begin
        checks++;
        if (out_data !== e_pix) fail("R1 R2 R3 R4 R6 R7 data", out_data, e_pix);
        checks++;
        if (out_sof !== (m_x == 0 && m_y == 0)) fail("R11 sof", {31'd0, out_sof}, {31'd0, (m_x == 0 && m_y == 0)});
        checks++;
        if (out_eol !== (m_x == m_w - 1)) fail("R8 R11 eol", {31'd0, out_eol}, {31'd0, (m_x == m_w - 1)});
      end
      // model update
      if (m_armed != 0) begin
        latch_model();
        m_armed = 0;
      end else if (e_valid && out_ready) begin
        for (int i = 0; i < NL; i++)
          if (cov[i]) begin
            void'(lq[i].pop_front());
            held[i] = 1'b0;
          end
        if (m_x == m_w - 1) begin
          m_x = 0;
          if (m_y == m_h - 1) begin
            m_y = 0; m_armed = 1; frame_idx++;
          end else m_y++;
        end else m_x++;
      end
      @(negedge clk);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule